// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker moves through a linked list of transfer descriptors held in a word-addressed memory. Each descriptor takes eight 32-bit words. They hold a source address, a destination address, a pointer to the following descriptor, a byte count, two burst sizes, a bytes-done count, a status byte and a control byte. Words 1, 3 and 5 are padding.

Software writes a chain into memory and gives the walker the word address of its first descriptor. It then pulses `start`. For each descriptor the walker reads the useful words and examines the ownership flag. If the descriptor belongs to the hardware, the walker passes the transfer fields to a data mover over a request/done handshake. When the mover finishes, the walker writes one word back to memory with the byte count and status reported by the mover, then follows the next pointer. A descriptor without the ownership flag ends the chain. In polling mode the walker instead waits a programmed delay and reads that same descriptor again.

Memory reads have one cycle of latency: data asked for in one cycle is on `rd_data` in the following cycle. Descriptor pointers are word addresses.

Top module: `desc_walker`

## Requirements
- R1: After `rst`, and one cycle after a `soft_reset` pulse, `busy`, `rd_en`, `wr_en` and `mv_req` are all low. A soft reset aborts a chain at any point, including while a transfer is in progress, and no write-back follows it.
- R2: For a descriptor at word address A, the walker reads A+0, A+2, A+4, A+6 and A+7, one word per cycle, in that order. Pad words A+1, A+3 and A+5 are never read.
- R3: A descriptor whose control byte has bit 7 (owned) set raises `mv_req`. While `mv_req` is high, `mv_raddr`, `mv_waddr` (words 0 and 2), `mv_bytes` (word 6 bits 15:0), `mv_rburst` (word 6 bits 23:16), `mv_wburst` (word 6 bits 31:24) and `mv_flags` = control bits 2:0 (bit 0 end of packet, bit 1 fixed read address, bit 2 fixed write address) stay constant. `mv_req` stays high until `mv_done` is sampled high.
- R4: After `mv_done` the walker issues exactly one write, to A+7. The data is {control[31:24], status[23:16], bytes-done[15:0]}. Status is `mv_status` with bit 6 (reserved) forced to 0, and bytes-done is `mv_xfer`.
- R5: When `own_keep` is 0, bit 31 of the write-back word (the owned flag) is cleared. When `own_keep` is 1 the captured control byte is written back unchanged.
- R6: After a write-back that does not halt the chain, the next descriptor is read from the word address held in word 4.
- R7: A descriptor with bit 7 clear and `poll_en` low ends the chain: no transfer and no write for it, and `busy` falls.
- R8: A descriptor with bit 7 clear and `poll_en` high keeps `busy` high. The same descriptor is read again starting at A+0, no fewer than `poll_delay` and no more than `poll_delay`+8 cycles after its control word was read.
- R9: With `stop_on_err` high, a write-back whose status bit 0 (error) is set ends the chain: `busy` falls and the next pointer is not followed. With `stop_on_err` low the chain continues.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking at `first_ptr` (one-cycle pulse) |
| soft_reset | input | 1 | Abort the walk and return to idle |
| first_ptr | input | AW | Word address of the first descriptor |
| poll_en | input | 1 | Re-read an unowned descriptor instead of stopping |
| poll_delay | input | PDW | Clocks to wait before the re-read |
| own_keep | input | 1 | 0: clear the owned flag on write-back; 1: keep it |
| stop_on_err | input | 1 | Halt the chain on an errored transfer |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read word address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write word address |
| wr_data | output | 32 | Memory write data |
| mv_req | output | 1 | Transfer request to the data mover |
| mv_raddr | output | 32 | Transfer source address |
| mv_waddr | output | 32 | Transfer destination address |
| mv_bytes | output | 16 | Transfer byte count |
| mv_rburst | output | 8 | Read burst size |
| mv_wburst | output | 8 | Write burst size |
| mv_flags | output | 3 | {fixed write, fixed read, end of packet} |
| mv_done | input | 1 | Mover finished the current transfer |
| mv_xfer | input | 16 | Bytes moved, sampled with `mv_done` |
| mv_status | input | 8 | Transfer status, sampled with `mv_done` |
| busy | output | 1 | A chain is being walked |

## Verification
A wrong read index or offset appears within the next few cycles as a read address that is out of sequence, or as a pad word being read. A corrupted captured field shows up as a wrong `mv_*` value when the request rises. A fault in the ownership, error or polling decisions does not show until the end of the descriptor. It then appears as a missing or extra request, a write-back word with the wrong owned or status bits, or a pointer that was not followed. In polling mode the bench also checks that `busy` falls, or the re-read begins, within a bounded window.

// File: rtl/desc_walker_pkg.sv
package desc_walker_pkg;

  // useful words of one descriptor, fetched in ascending order
  localparam int FETCH_N   = 5;
  localparam int CTRL_WORD = 7;
  localparam int OWN_BIT   = 7;
  localparam int ERR_BIT   = 0;
  localparam int RSVD_BIT  = 6;

  typedef struct packed {
    logic [31:0] raddr;
    logic [31:0] waddr;
    logic [31:0] nxt;
    logic [15:0] bytes;
    logic [7:0]  rburst;
    logic [7:0]  wburst;
    logic [7:0]  ctrl;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_MOVE, ST_WB, ST_POLL
  } walk_st_e;

  // word offset of the n-th useful word: 0,2,4,6,7
  function automatic logic [2:0] word_ofs(input logic [2:0] n);
    return (n >= 3'(FETCH_N - 1)) ? 3'(CTRL_WORD) : {n[1:0], 1'b0};
  endfunction

endpackage

// File: rtl/dw_fetch.sv
module dw_fetch import desc_walker_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          go,
  input  logic [AW-1:0] base,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          done,
  output desc_t         desc
);

  localparam int IW = 3;

  logic [IW-1:0] iss, cap;
  logic          active, pend;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active  <= 1'b0;
      pend    <= 1'b0;
      rd_en   <= 1'b0;
      iss     <= '0;
      cap     <= '0;
      done    <= 1'b0;
      rd_addr <= '0;
    end else begin
      done <= 1'b0;
      pend <= rd_en;
      rd_en <= 1'b0;
      if (go) begin
        active <= 1'b1;
        iss    <= '0;
        cap    <= '0;
      end else if (active && iss < IW'(FETCH_N)) begin
        rd_en   <= 1'b1;
        rd_addr <= base + AW'(word_ofs(iss));
        iss     <= iss + 1'b1;
      end
      if (pend) begin
        case (cap)
          3'd0:    desc.raddr <= rd_data;
          3'd1:    desc.waddr <= rd_data;
          3'd2:    desc.nxt   <= rd_data;
          3'd3:    {desc.wburst, desc.rburst, desc.bytes} <= rd_data;
          default: desc.ctrl  <= rd_data[31:24];
        endcase
        cap <= cap + 1'b1;
        if (cap == IW'(FETCH_N - 1)) begin
          done   <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dw_poll_timer.sv
module dw_poll_timer #(
  parameter int PDW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           abort,
  input  logic           load,
  input  logic [PDW-1:0] delay,
  output logic           fire
);

  logic [PDW-1:0] cnt;
  logic           run;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run  <= 1'b0;
      fire <= 1'b0;
      cnt  <= '0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt <= delay;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          fire <= 1'b1;
          run  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/desc_walker.sv
module desc_walker import desc_walker_pkg::*; #(
  parameter int AW  = 32,
  parameter int PDW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           soft_reset,
  input  logic [AW-1:0]  first_ptr,
  input  logic           poll_en,
  input  logic [PDW-1:0] poll_delay,
  input  logic           own_keep,
  input  logic           stop_on_err,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [31:0]    rd_data,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [31:0]    wr_data,
  output logic           mv_req,
  output logic [31:0]    mv_raddr,
  output logic [31:0]    mv_waddr,
  output logic [15:0]    mv_bytes,
  output logic [7:0]     mv_rburst,
  output logic [7:0]     mv_wburst,
  output logic [2:0]     mv_flags,
  input  logic           mv_done,
  input  logic [15:0]    mv_xfer,
  input  logic [7:0]     mv_status,
  output logic           busy
);

  localparam logic [AW-1:0] WB_OFS = AW'(CTRL_WORD);

  walk_st_e      st;
  logic [AW-1:0] cur;
  logic          fetch_go, f_done, poll_load, p_fire, last_err;
  desc_t         d;
  logic [7:0]    wb_ctrl, wb_stat;

  dw_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .abort(soft_reset), .go(fetch_go), .base(cur),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(f_done), .desc(d)
  );

  dw_poll_timer #(.PDW(PDW)) u_timer (
    .clk(clk), .rst(rst), .abort(soft_reset), .load(poll_load),
    .delay(poll_delay), .fire(p_fire)
  );

  always_comb begin
    wb_ctrl = d.ctrl;
    if (!own_keep) wb_ctrl[OWN_BIT] = 1'b0;
    wb_stat = mv_status;
    wb_stat[RSVD_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_reset) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      mv_req    <= 1'b0;
      wr_en     <= 1'b0;
      fetch_go  <= 1'b0;
      poll_load <= 1'b0;
      last_err  <= 1'b0;
      cur       <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      fetch_go  <= 1'b0;
      poll_load <= 1'b0;
      wr_en     <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cur      <= first_ptr;
          busy     <= 1'b1;
          fetch_go <= 1'b1;
          st       <= ST_FETCH;
        end
        ST_FETCH: if (f_done) begin
          if (d.ctrl[OWN_BIT]) begin
            mv_req    <= 1'b1;
            mv_raddr  <= d.raddr;
            mv_waddr  <= d.waddr;
            mv_bytes  <= d.bytes;
            mv_rburst <= d.rburst;
            mv_wburst <= d.wburst;
            mv_flags  <= d.ctrl[2:0];
            st        <= ST_MOVE;
          end else if (poll_en) begin
            poll_load <= 1'b1;
            st        <= ST_POLL;
          end else begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end
        end
        ST_MOVE: if (mv_done) begin
          mv_req   <= 1'b0;
          wr_en    <= 1'b1;
          wr_addr  <= cur + WB_OFS;
          wr_data  <= {wb_ctrl, wb_stat, mv_xfer};
          last_err <= mv_status[ERR_BIT];
          st       <= ST_WB;
        end
        ST_WB: begin
          if (stop_on_err && last_err) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            cur      <= AW'(d.nxt);
            fetch_go <= 1'b1;
            st       <= ST_FETCH;
          end
        end
        ST_POLL: if (p_fire) begin
          fetch_go <= 1'b1;
          st       <= ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

module desc_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_reset,
  input logic          own_keep,
  input logic          rd_en,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          mv_req,
  input logic          mv_done,
  input logic [31:0]   mv_raddr,
  input logic [31:0]   mv_waddr,
  input logic [15:0]   mv_bytes,
  input logic [2:0]    mv_flags,
  input logic          busy
);

  // R1
  sreset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> (!busy && !mv_req && !wr_en && !rd_en));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_en && !wr_en && !mv_req));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_req && !mv_done && !soft_reset) |=> mv_req);

  // R3
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_req && $past(mv_req)) |-> ($stable(mv_raddr) && $stable(mv_waddr)
                                   && $stable(mv_bytes) && $stable(mv_flags)));

  // R4
  wb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4
  wb_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(mv_req && mv_done));

  // R4
  wb_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !wr_data[22]);

  // R5
  wb_own_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[31] == $past(own_keep)));

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

endmodule

bind desc_walker desc_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .soft_reset(soft_reset), .own_keep(own_keep),
  .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .mv_req(mv_req),
  .mv_done(mv_done), .mv_raddr(mv_raddr), .mv_waddr(mv_waddr),
  .mv_bytes(mv_bytes), .mv_flags(mv_flags), .busy(busy)
);

// File: tb/desc_walker_test.sv
`timescale 1ns/1ps
module desc_walker_test;

  localparam int AW = 32;
  localparam int PDW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, soft_reset, poll_en, own_keep, stop_on_err;
  logic [AW-1:0] first_ptr;
  logic [PDW-1:0] poll_delay;
  logic rd_en, wr_en, mv_req, mv_done, busy;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data, mv_raddr, mv_waddr;
  logic [15:0] mv_bytes, mv_xfer;
  logic [7:0] mv_rburst, mv_wburst, mv_status;
  logic [2:0] mv_flags;

  desc_walker #(.AW(AW), .PDW(PDW)) uut (
    .clk(clk), .rst(rst), .start(start), .soft_reset(soft_reset),
    .first_ptr(first_ptr), .poll_en(poll_en), .poll_delay(poll_delay),
    .own_keep(own_keep), .stop_on_err(stop_on_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mv_req(mv_req), .mv_raddr(mv_raddr), .mv_waddr(mv_waddr),
    .mv_bytes(mv_bytes), .mv_rburst(mv_rburst), .mv_wburst(mv_wburst),
    .mv_flags(mv_flags), .mv_done(mv_done), .mv_xfer(mv_xfer),
    .mv_status(mv_status), .busy(busy)
  );

  // memory model: one cycle read latency, bench port has priority
  logic [31:0] mem [0:255];
  logic tb_we;
  logic [7:0] tb_wa;
  logic [31:0] tb_wd;
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[7:0]];
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (wr_en) mem[wr_addr[7:0]] <= wr_data;
  end

  int n_chk, n_fail;
  int cyc, rd_cnt, mv_cnt, wr_cnt, resp_i;
  bit mon_on, resp_hold, prev_req;
  logic [31:0] exp_rd [0:63];
  logic [31:0] rd_log_a [0:63];
  int rd_log_t [0:63];
  logic [31:0] e_ra [0:7], e_wa [0:7], e_wr [0:7], e_wad [0:7];
  logic [15:0] e_by [0:7];
  logic [7:0] e_rb [0:7], e_wb [0:7];
  logic [2:0] e_fl [0:7];
  logic [15:0] r_x [0:7];
  logic [7:0] r_s [0:7];
  int n_exp_rd, n_exp_mv, n_exp_wr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_counts();
    rd_cnt = 0; mv_cnt = 0; wr_cnt = 0; resp_i = 0;
  endtask

  // builds a chain of n_own owned descriptors plus one unowned terminator
  // and computes every read, request and write-back the requirements imply
  task automatic build_chain(input int n_own, input bit keep, input bit stop,
                             input bit force_err, output logic [31:0] head);
    int k;
    bit halted;
    logic [31:0] addr [0:7];
    k = int'($urandom % 16);
    for (int i = 0; i <= n_own; i++) addr[i] = 32'(((i * 3 + k) % 16) * 8);
    n_exp_rd = 0; n_exp_mv = 0; n_exp_wr = 0; halted = 0;
    for (int i = 0; i <= n_own; i++) begin
      logic [31:0] ra, wa, w6;
      logic [7:0] ctl;
      ra = $urandom; wa = $urandom; w6 = $urandom;
      ctl = {(i < n_own), 4'b0000, 3'($urandom % 8)};
      poke(addr[i][7:0], ra);
      poke(addr[i][7:0] + 8'd1, 32'hDEAD_0001);
      poke(addr[i][7:0] + 8'd2, wa);
      poke(addr[i][7:0] + 8'd3, 32'hDEAD_0003);
      poke(addr[i][7:0] + 8'd4, (i < n_own) ? addr[i+1] : addr[0]);
      poke(addr[i][7:0] + 8'd5, 32'hDEAD_0005);
      poke(addr[i][7:0] + 8'd6, w6);
      poke(addr[i][7:0] + 8'd7, {ctl, 8'h5A, 16'h1234});
      if (!halted) begin
        exp_rd[n_exp_rd]   = addr[i];
        exp_rd[n_exp_rd+1] = addr[i] + 2;
        exp_rd[n_exp_rd+2] = addr[i] + 4;
        exp_rd[n_exp_rd+3] = addr[i] + 6;
        exp_rd[n_exp_rd+4] = addr[i] + 7;
        n_exp_rd += 5;
        if (i < n_own) begin
          logic [7:0] s, c;
          r_x[i] = 16'($urandom);
          s = 8'($urandom);
          s[0] = (force_err && i == 0) ? 1'b1 : ($urandom % 4 == 0);
          r_s[i] = s;
          e_ra[i] = ra; e_wa[i] = wa; e_by[i] = w6[15:0];
          e_rb[i] = w6[23:16]; e_wb[i] = w6[31:24]; e_fl[i] = ctl[2:0];
          c = ctl;
          if (!keep) c[7] = 1'b0;
          s[6] = 1'b0;
          e_wad[i] = addr[i] + 7;
          e_wr[i]  = {c, s, r_x[i]};
          n_exp_mv++; n_exp_wr++;
          if (stop && r_s[i][0]) halted = 1;
        end
      end
    end
    head = addr[0];
  endtask

  task automatic run_chain(input int n_own, input bit keep, input bit stop,
                           input bit force_err);
    logic [31:0] head;
    int guard;
    build_chain(n_own, keep, stop, force_err, head);
    own_keep = keep; stop_on_err = stop; poll_en = 1'b0;
    clear_counts();
    mon_on = 1'b1;
    first_ptr = head;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(rd_cnt == n_exp_rd, "R6/R9 read count", 64'(rd_cnt), 64'(n_exp_rd));
    chk(mv_cnt == n_exp_mv, "R7/R9 request count", 64'(mv_cnt), 64'(n_exp_mv));
    chk(wr_cnt == n_exp_wr, "R4 write count", 64'(wr_cnt), 64'(n_exp_wr));
    chk(busy == 1'b0, "R7 busy at chain end", 64'(busy), 64'd0);
    mon_on = 1'b0;
  endtask

  task automatic wait_reads(input int n);
    int guard;
    guard = 0;
    while (rd_cnt < n && guard < 400) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // monitor: compares every port event against the precomputed lists
  task automatic monitor();
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_en) begin
        if (rd_cnt < 64) begin
          rd_log_a[rd_cnt] = rd_addr;
          rd_log_t[rd_cnt] = cyc;
          if (mon_on)
            chk(rd_cnt < n_exp_rd && rd_addr == exp_rd[rd_cnt],
                "R2 read address", 64'(rd_addr), 64'(exp_rd[rd_cnt]));
        end
        rd_cnt++;
      end
      if (mv_req && !prev_req) begin
        if (mon_on && mv_cnt < 8) begin
          chk(mv_raddr == e_ra[mv_cnt], "R3 raddr", 64'(mv_raddr), 64'(e_ra[mv_cnt]));
          chk(mv_waddr == e_wa[mv_cnt], "R3 waddr", 64'(mv_waddr), 64'(e_wa[mv_cnt]));
          chk({mv_wburst, mv_rburst, mv_bytes} == {e_wb[mv_cnt], e_rb[mv_cnt], e_by[mv_cnt]},
              "R3 count and bursts", 64'({mv_wburst, mv_rburst, mv_bytes}),
              64'({e_wb[mv_cnt], e_rb[mv_cnt], e_by[mv_cnt]}));
          chk(mv_flags == e_fl[mv_cnt], "R3 flags", 64'(mv_flags), 64'(e_fl[mv_cnt]));
        end
        mv_cnt++;
      end
      prev_req = mv_req;
      if (wr_en) begin
        if (mon_on && wr_cnt < 8) begin
          chk(wr_addr == e_wad[wr_cnt], "R4 write address", 64'(wr_addr), 64'(e_wad[wr_cnt]));
          chk(wr_data == e_wr[wr_cnt], "R4/R5 write data", 64'(wr_data), 64'(e_wr[wr_cnt]));
        end
        wr_cnt++;
      end
    end
  endtask

  // data mover model: random latency, then a one-cycle done pulse
  task automatic responder();
    forever begin
      @(negedge clk);
      if (mv_req && !resp_hold) begin
        repeat ($urandom % 5) @(negedge clk);
        if (mv_req && !resp_hold) begin
          mv_xfer = r_x[resp_i[2:0]];
          mv_status = r_s[resp_i[2:0]];
          mv_done = 1'b1;
          @(negedge clk);
          mv_done = 1'b0;
          resp_i++;
        end
      end
    end
  endtask

  initial begin
    int gap;
    int wr_before;
    process::self().srandom(32'h5EED_0042);
    rst = 1'b1; start = 1'b0; soft_reset = 1'b0; poll_en = 1'b0;
    own_keep = 1'b0; stop_on_err = 1'b0; first_ptr = '0; poll_delay = '0;
    mv_done = 1'b0; mv_xfer = '0; mv_status = '0;
    tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
    n_chk = 0; n_fail = 0; cyc = 0; mon_on = 1'b0; resp_hold = 1'b0;
    prev_req = 1'b0;
    clear_counts();
    for (int i = 0; i < 8; i++) begin r_x[i] = '0; r_s[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      monitor();
      responder();
    join_none
    @(negedge clk);
    // R1 reset state
    chk({busy, rd_en, wr_en, mv_req} == 4'b0, "R1 reset outputs",
        64'({busy, rd_en, wr_en, mv_req}), 64'd0);

    // directed: empty chain ends at once (R7)
    run_chain(0, 1'b0, 1'b0, 1'b0);
    // directed: error on first descriptor with halt enabled (R9)
    run_chain(3, 1'b0, 1'b1, 1'b1);
    // directed: error present but halt disabled, chain continues (R9)
    run_chain(3, 1'b1, 1'b0, 1'b1);
    // random chains (R2 to R7, R9)
    for (int t = 0; t < 10; t++)
      run_chain(int'($urandom % 5), 1'($urandom), 1'($urandom), 1'b0);

    // R1: soft reset during an active transfer
    resp_hold = 1'b1;
    begin
      logic [31:0] head;
      build_chain(1, 1'b0, 1'b0, 1'b0, head);
      clear_counts();
      first_ptr = head;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_reads(5);
      repeat (4) @(negedge clk);
      chk(mv_req == 1'b1, "R1 request pending before soft reset", 64'(mv_req), 64'd1);
      soft_reset = 1'b1;
      @(negedge clk);
      soft_reset = 1'b0;
      chk({busy, mv_req} == 2'b00, "R1 soft reset clears", 64'({busy, mv_req}), 64'd0);
      repeat (10) @(negedge clk);
      chk(wr_cnt == 0, "R1 no write-back after abort", 64'(wr_cnt), 64'd0);
    end
    resp_hold = 1'b0;

    // R8 / R10 / R5: polling an unowned descriptor at word 0x40
    poke(8'h40, 32'hA000_0000);
    poke(8'h42, 32'hB000_0000);
    poke(8'h44, 32'h0000_0040);
    poke(8'h46, 32'h0403_0100);
    poke(8'h47, 32'h0000_0000);
    r_x[0] = 16'h0100; r_s[0] = 8'h00;
    clear_counts();
    poll_en = 1'b1; poll_delay = 8'd20; own_keep = 1'b0; stop_on_err = 1'b0;
    first_ptr = 32'h40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_reads(6);
    chk(rd_log_a[5] == 32'h40, "R8 re-read same descriptor", 64'(rd_log_a[5]), 64'h40);
    gap = rd_log_t[5] - rd_log_t[4];
    chk(gap >= 20 && gap <= 28, "R8 poll delay", 64'(gap), 64'd20);
    chk(busy == 1'b1, "R8 busy while polling", 64'(busy), 64'd1);
    first_ptr = 32'h80;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_reads(11);
    chk(rd_log_a[10] == 32'h40, "R10 start ignored while busy", 64'(rd_log_a[10]), 64'h40);
    chk(mv_cnt == 0, "R8 no transfer for unowned", 64'(mv_cnt), 64'd0);
    // hand the descriptor to hardware; it points at itself
    poke(8'h47, 32'h8100_0000);
    wr_before = wr_cnt;
    begin
      int guard;
      guard = 0;
      while (wr_cnt == wr_before && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(mv_cnt == 1, "R8 owned after poll moves", 64'(mv_cnt), 64'd1);
    chk(mem[8'h47] == 32'h0100_0100, "R5 owned flag cleared", 64'(mem[8'h47]), 64'h0100_0100);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1 && mv_cnt == 1, "R8 polling resumes on cleared owner",
        64'({busy, 8'(mv_cnt)}), 64'h101);
    soft_reset = 1'b1;
    @(negedge clk);
    soft_reset = 1'b0;
    chk(busy == 1'b0, "R1 soft reset ends polling", 64'(busy), 64'd0);
    repeat (30) @(negedge clk);
    chk(rd_en == 1'b0 && busy == 1'b0, "R1 stays idle", 64'({rd_en, busy}), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule